// File: doc/BRIEF.md
# I2C Bus Phase Timing Generator

This block sits between an I2C transaction engine and the open-drain pads. The engine hands it one bus step at a time: a START, a repeated START, a STOP, a data bit to send, or a bit to receive. The block lays the step out on SCL and SDA as a series of timed phases and reports when the step is complete. Each phase length comes from a programmable tick count, and each tick comes from a shared prescaler. Computing the count values is left to software or to the engine.

The pads are driven as pull-down enables: a 1 on an enable pulls the line low, and a 0 releases it. The block reads the real bus levels back through a synchronizer and a glitch filter of programmable length. It therefore does not count SCL high time until the line has really risen, which lets a slave stretch the clock. On every data-bit step the SDA level sampled at the end of the SCL high phase is returned, so the engine gets read data and can also check its own written bits.

Top module: `i2c_bus_phase_gen`

## Requirements
- R1: After reset both pull-down enables are 0, `step_done` is 0 and `step_ready` is 1.
- R2: A counted phase with count N lasts exactly (N+1)·(`cfg_prescale`+1) clock cycles, measured from the clock edge that enters it to the clock edge that leaves it.
- R3: START (op code 0) is accepted only while the block does not hold SCL low. It keeps both lines released for the start-setup count, then pulls SDA low for the start-hold count, then pulls SCL low and pulses `step_done` for one cycle.
- R4: On every step that begins with SCL held low, SCL stays low for (hold + low + setup + 3)·(`cfg_prescale`+1) cycles. SDA keeps its old level for exactly (`cfg_dat_hd`+1)·(`cfg_prescale`+1) cycles and changes only then. The middle count is `cfg_scl_low`, or `cfg_rel` for a repeated START.
- R5: After SCL is released, the high phase starts counting 3+`cfg_filt` cycles after the first clock edge that captures SCL high. A bit step ends (SCL pulled low, `step_done`) after a further (`cfg_scl_high`+1)·(`cfg_prescale`+1) cycles.
- R6: While a slave holds SCL low after the block releases it, the block neither counts the high phase nor pulls SCL low. The R5 timing applies from the edge that first captures SCL released.
- R7: A write step (op code 3) pulls SDA low for `step_bit`=0 and releases it for `step_bit`=1.
- R8: A read step (op code 4) releases SDA. At `step_done` of a read or write step, `rx_bit` equals the filtered SDA level at the end of the high phase.
- R9: STOP (op code 1) pulls SDA low during the low phase and releases SCL. After the stop-setup count it releases SDA and pulses `step_done`, leaving both lines released.
- R10: A repeated START (op code 2) releases SDA during the low phase and releases SCL. After the start-setup count it pulls SDA low, and after the start-hold count it pulls SCL low and pulses `step_done`.
- R11: A START while SCL is held, or any other step while SCL is not held, is ignored: no `step_done`, no line change, and `step_ready` stays 1.
- R12: A change on SCL or SDA is accepted only after the synchronized level has differed from the accepted level for `cfg_filt`+1 consecutive cycles. A shorter pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prescale | input | 8 | Tick divider minus one |
| cfg_filt | input | 3 | Glitch filter length |
| cfg_start_su | input | 8 | START setup count |
| cfg_start_hd | input | 8 | START hold count |
| cfg_stop_su | input | 8 | STOP setup count |
| cfg_dat_su | input | 8 | SDA setup count before SCL rises |
| cfg_dat_hd | input | 8 | SDA hold count after SCL falls |
| cfg_scl_low | input | 8 | SCL low count (middle part) |
| cfg_scl_high | input | 8 | SCL high count |
| cfg_rel | input | 8 | SDA release count before a repeated START |
| step_valid | input | 1 | Step request |
| step_op | input | 3 | Step code: 0 START, 1 STOP, 2 repeated START, 3 write, 4 read |
| step_bit | input | 1 | Bit value for a write step |
| step_ready | output | 1 | Block is idle and takes a step |
| step_done | output | 1 | One-cycle pulse when a step ends |
| rx_bit | output | 1 | SDA sampled in the last bit step |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Every line edge and done pulse is predicted to the exact cycle from the counts and compared in order. Each step kind is run back to back, with two prescaler and filter settings. This separates a wrong tick divider from a wrong phase count and from wrong synchronizer latency. Writes of 0 and 1 and reads with the slave pulling or releasing SDA separate the driven level from the sampled level. Stretched high phases, with and without a filter-length glitch inside the stretch, show that counting waits for a filtered SCL high. Illegal steps in both bus states show that they leave the lines untouched.

// File: rtl/i2c_tmr_pkg.sv
// Shared step codes and phase encoding for the I2C bus phase generator.
// Assumes: step codes are fixed by the transaction engine interface.
package i2c_tmr_pkg;
    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_RESTART = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } step_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SU,
        PH_HD,
        PH_LHOLD,
        PH_LDRV,
        PH_LSET,
        PH_HWAIT,
        PH_HCNT
    } phase_e;
endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizes one bus line and rejects pulses shorter than filt_len+1 cycles.
// Assumes: filt_len is static while the bus is active; released level is 1.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              line_in,
    output logic              line_out
);
    logic              sync_out;
    logic [FILT_W-1:0] run_cnt;
    logic              out_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            logic [SYNC_STAGES-1:0] sync_q;
            // shift the raw level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
            assign sync_out = sync_q[SYNC_STAGES-1];
        end else begin : g_single
            logic sync_q;
            // single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= line_in;
            end
            assign sync_out = sync_q;
        end
    endgenerate

    // accept a new level only after it persisted long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= 1'b1;
            run_cnt <= '0;
        end else if (sync_out != out_q) begin
            if (run_cnt == filt_len) begin
                out_q   <= sync_out;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign line_out = out_q;

    AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(run_cnt) == $past(filt_len))); // R12
endmodule

// File: rtl/i2c_phase_counter.sv
// Prescaled down-counter that times one bus phase; restarts on load.
// Assumes: prescale is static during a phase. expire marks the last cycle.
module i2c_phase_counter #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick   = (pre_q == prescale);
    assign expire = tick && (cnt_q == '0);

    // prescaler and tick counter; both restart on a phase load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (tick) begin
            pre_q <= '0;
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/i2c_bus_phase_gen.sv
// I2C bus phase generator: turns one step request into timed SCL/SDA phases.
// Assumes: pads are open drain (oe=1 pulls low); cfg inputs static per step.
module i2c_bus_phase_gen
    import i2c_tmr_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int CNT_W  = 8,
    parameter int FILT_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic [CNT_W-1:0]  cfg_start_su,
    input  logic [CNT_W-1:0]  cfg_start_hd,
    input  logic [CNT_W-1:0]  cfg_stop_su,
    input  logic [CNT_W-1:0]  cfg_dat_su,
    input  logic [CNT_W-1:0]  cfg_dat_hd,
    input  logic [CNT_W-1:0]  cfg_scl_low,
    input  logic [CNT_W-1:0]  cfg_scl_high,
    input  logic [CNT_W-1:0]  cfg_rel,
    input  logic              step_valid,
    input  logic [2:0]        step_op,
    input  logic              step_bit,
    output logic              step_ready,
    output logic              step_done,
    output logic              rx_bit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int LINES = 2;

    phase_e           phase_q, phase_d;
    step_op_e         op_q, op_in;
    logic             bit_q;
    logic             scl_low_q, sda_low_q, done_q, rx_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             legal, accept;
    logic             new_sda_low;
    logic [LINES-1:0] raw_lines, seen_lines;
    logic             scl_seen, sda_seen;

    assign raw_lines = {sda_in, scl_in};

    generate
        for (genvar li = 0; li < LINES; li++) begin : g_filt
            i2c_line_filter #(.SYNC_STAGES(SYNC_N), .FILT_W(FILT_W)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .filt_len (cfg_filt),
                .line_in  (raw_lines[li]),
                .line_out (seen_lines[li])
            );
        end
    endgenerate

    assign scl_seen = seen_lines[0];
    assign sda_seen = seen_lines[1];

    i2c_phase_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .prescale (cfg_prescale),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    // decide whether the requested step fits the current bus ownership
    always_comb begin
        op_in = step_op_e'(step_op);
        case (op_in)
            OP_START:                            legal = !scl_low_q;
            OP_STOP, OP_RESTART, OP_WRITE, OP_READ: legal = scl_low_q;
            default:                             legal = 1'b0;
        endcase
        accept = step_valid && (phase_q == PH_IDLE) && legal;
    end

    // SDA level requested for the data part of the low phase
    always_comb begin
        case (op_q)
            OP_WRITE: new_sda_low = !bit_q;
            OP_STOP:  new_sda_low = 1'b1;
            default:  new_sda_low = 1'b0;
        endcase
    end

    // next phase and the count loaded on entry to it
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        case (phase_q)
            PH_IDLE: if (accept) begin
                load = 1'b1;
                if (op_in == OP_START) begin
                    phase_d  = PH_SU;
                    load_val = cfg_start_su;
                end else begin
                    phase_d  = PH_LHOLD;
                    load_val = cfg_dat_hd;
                end
            end
            PH_SU: if (expire) begin
                phase_d  = PH_HD;
                load     = 1'b1;
                load_val = cfg_start_hd;
            end
            PH_HD: if (expire) phase_d = PH_IDLE;
            PH_LHOLD: if (expire) begin
                phase_d  = PH_LDRV;
                load     = 1'b1;
                load_val = (op_q == OP_RESTART) ? cfg_rel : cfg_scl_low;
            end
            PH_LDRV: if (expire) begin
                phase_d  = PH_LSET;
                load     = 1'b1;
                load_val = cfg_dat_su;
            end
            PH_LSET: if (expire) phase_d = PH_HWAIT;
            PH_HWAIT: if (scl_seen) begin
                phase_d  = PH_HCNT;
                load     = 1'b1;
                case (op_q)
                    OP_STOP:    load_val = cfg_stop_su;
                    OP_RESTART: load_val = cfg_start_su;
                    default:    load_val = cfg_scl_high;
                endcase
            end
            PH_HCNT: if (expire) begin
                if (op_q == OP_RESTART) begin
                    phase_d  = PH_HD;
                    load     = 1'b1;
                    load_val = cfg_start_hd;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // phase register and the latched step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_START;
            bit_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                op_q  <= op_in;
                bit_q <= step_bit;
            end
        end
    end

    // line enables, done pulse and sampled bit, updated at phase ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_SU:    if (expire) sda_low_q <= 1'b1;
                PH_HD:    if (expire) begin
                    scl_low_q <= 1'b1;
                    done_q    <= 1'b1;
                end
                PH_LHOLD: if (expire) sda_low_q <= new_sda_low;
                PH_LSET:  if (expire) scl_low_q <= 1'b0;
                PH_HCNT:  if (expire) begin
                    case (op_q)
                        OP_RESTART: sda_low_q <= 1'b1;
                        OP_STOP: begin
                            sda_low_q <= 1'b0;
                            done_q    <= 1'b1;
                        end
                        default: begin
                            scl_low_q <= 1'b1;
                            done_q    <= 1'b1;
                            rx_q      <= sda_seen;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign scl_oe     = scl_low_q;
    assign sda_oe     = sda_low_q;
    assign step_done  = done_q;
    assign rx_bit     = rx_q;
    assign step_ready = (phase_q == PH_IDLE);

    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low_q) && $past(phase_q) != PH_SU && $past(phase_q) != PH_HCNT)
        |-> $past(scl_low_q)); // R4
    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HWAIT && !scl_seen) |=> (phase_q == PH_HWAIT && !scl_low_q)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done); // R3
    AST_IGNORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && step_valid && !legal)
        |=> (phase_q == PH_IDLE && $stable(scl_low_q) && $stable(sda_low_q) && !step_done)); // R11
endmodule

// File: tb/i2c_bus_phase_gen_tb_top.sv
// Scoreboard bench: the driver predicts every line edge and done pulse with
// its cycle number; a monitor compares what the design produces.
module i2c_bus_phase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_prescale, cfg_start_su, cfg_start_hd, cfg_stop_su;
    logic [7:0] cfg_dat_su, cfg_dat_hd, cfg_scl_low, cfg_scl_high, cfg_rel;
    logic [2:0] cfg_filt;
    logic       step_valid = 1'b0;
    logic [2:0] step_op = 3'd0;
    logic       step_bit = 1'b0;
    logic       step_ready, step_done, rx_bit;
    logic       scl_oe, sda_oe, scl_in, sda_in;
    logic       slv_scl_hold = 1'b0;
    logic       slv_sda_pull = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    bit scl_prev, sda_prev;
    bit m_sda = 1'b0;

    typedef struct {
        int    kind;
        int    t;
        bit    val;
        bit    chk;
        string req;
    } ev_t;
    ev_t exp_q[$];

    localparam int EV_SCL_LOW = 0;
    localparam int EV_SCL_REL = 1;
    localparam int EV_SDA_LOW = 2;
    localparam int EV_SDA_REL = 3;
    localparam int EV_DONE    = 4;

    assign scl_in = !scl_oe && !slv_scl_hold;
    assign sda_in = !sda_oe && !slv_sda_pull;

    always #4 clk = !clk;

    always @(posedge clk) cyc <= cyc + 1;

    i2c_bus_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_prescale(cfg_prescale), .cfg_filt(cfg_filt),
        .cfg_start_su(cfg_start_su), .cfg_start_hd(cfg_start_hd),
        .cfg_stop_su(cfg_stop_su), .cfg_dat_su(cfg_dat_su),
        .cfg_dat_hd(cfg_dat_hd), .cfg_scl_low(cfg_scl_low),
        .cfg_scl_high(cfg_scl_high), .cfg_rel(cfg_rel),
        .step_valid(step_valid), .step_op(step_op), .step_bit(step_bit),
        .step_ready(step_ready), .step_done(step_done), .rx_bit(rx_bit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int kind, input int t, input bit val, input bit chk, input string req);
        ev_t e;
        e.kind = kind; e.t = t; e.val = val; e.chk = chk; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor side: compare one observed event against the queue head
    task automatic got(input int kind, input bit val);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event", kind, -1);
            return;
        end
        e = exp_q.pop_front();
        check(e.kind == kind, {e.req, " kind"}, kind, e.kind);
        check(e.t == cyc, {e.req, " cycle"}, cyc, e.t);
        if (e.chk) check(e.val == val, {e.req, " rx_bit"}, val, e.val);
    endtask

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (sda_oe != sda_prev) got(sda_oe ? EV_SDA_LOW : EV_SDA_REL, 1'b0);
            if (scl_oe != scl_prev) got(scl_oe ? EV_SCL_LOW : EV_SCL_REL, 1'b0);
            if (step_done) got(EV_DONE, rx_bit);
        end
        sda_prev = sda_oe;
        scl_prev = scl_oe;
    end

    // driver: issue one step, predict its events, run the slave model
    task automatic do_step(input int op, input bit b, input int stretch,
                           input int glitch, input bit pull, input string req);
        int m, a, lenl, k, base, t1, drv;
        bit nsda;
        m = int'(cfg_prescale) + 1;
        @(negedge clk);
        step_valid = 1'b1; step_op = 3'(op); step_bit = b;
        @(posedge clk); #1;
        a = cyc;
        step_valid = 1'b0;
        if (op == 0) begin
            push(EV_SDA_LOW, a + (int'(cfg_start_su) + 1) * m, 0, 0, {req, " R2 R3 start sda"});
            m_sda = 1'b1;
            t1 = a + (int'(cfg_start_su) + int'(cfg_start_hd) + 2) * m;
            push(EV_SCL_LOW, t1, 0, 0, {req, " R2 R3 start scl"});
            push(EV_DONE, t1, 0, 0, {req, " R3 start done"});
        end else begin
            nsda = (op == 3) ? !b : (op == 1);
            drv  = (op == 2) ? int'(cfg_rel) : int'(cfg_scl_low);
            lenl = (int'(cfg_dat_hd) + drv + int'(cfg_dat_su) + 3) * m;
            if (nsda != m_sda)
                push(nsda ? EV_SDA_LOW : EV_SDA_REL, a + (int'(cfg_dat_hd) + 1) * m, 0, 0,
                     {req, " R4 R7 sda after hold"});
            m_sda = nsda;
            push(EV_SCL_REL, a + lenl, 0, 0, {req, " R4 low length"});
            k    = (stretch > 0) ? a + lenl + stretch + 1 : a + lenl + 1;
            base = k + 3 + int'(cfg_filt);
            if (op == 3 || op == 4) begin
                t1 = base + (int'(cfg_scl_high) + 1) * m;
                push(EV_SCL_LOW, t1, 0, 0, {req, " R5 R6 high length"});
                push(EV_DONE, t1, !m_sda && !pull, 1'b1, {req, " R8 rx sample"});
            end else if (op == 1) begin
                t1 = base + (int'(cfg_stop_su) + 1) * m;
                push(EV_SDA_REL, t1, 0, 0, {req, " R9 stop sda release"});
                push(EV_DONE, t1, 0, 0, {req, " R9 stop done"});
                m_sda = 1'b0;
            end else begin
                t1 = base + (int'(cfg_start_su) + 1) * m;
                push(EV_SDA_LOW, t1, 0, 0, {req, " R10 restart sda"});
                m_sda = 1'b1;
                t1 = t1 + (int'(cfg_start_hd) + 1) * m;
                push(EV_SCL_LOW, t1, 0, 0, {req, " R10 restart scl"});
                push(EV_DONE, t1, 0, 0, {req, " R10 restart done"});
            end
            if (op == 4) slv_sda_pull = pull;
            if (stretch > 0) begin
                slv_scl_hold = 1'b1;
                while (cyc < a + lenl + stretch) begin
                    @(negedge clk);
                    if (glitch > 0 && cyc == a + lenl + 2) slv_scl_hold = 1'b0;
                    if (glitch > 0 && cyc == a + lenl + 2 + glitch) slv_scl_hold = 1'b1;
                end
                slv_scl_hold = 1'b0;
            end
        end
        while (!step_done) @(negedge clk);
        @(negedge clk);
        slv_sda_pull = 1'b0;
    endtask

    // illegal request: must leave lines, ready and done untouched
    task automatic bad_step(input int op, input string req);
        bit s0, d0;
        @(negedge clk);
        s0 = scl_oe; d0 = sda_oe;
        step_valid = 1'b1; step_op = 3'(op);
        @(negedge clk);
        step_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(scl_oe == s0, {req, " R11 scl kept"}, scl_oe, s0);
        check(sda_oe == d0, {req, " R11 sda kept"}, sda_oe, d0);
        check(step_ready == 1'b1, {req, " R11 ready"}, step_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg_prescale = 8'd1; cfg_filt = 3'd2;
        cfg_start_su = 8'd3; cfg_start_hd = 8'd2; cfg_stop_su = 8'd4;
        cfg_dat_su = 8'd1; cfg_dat_hd = 8'd1; cfg_scl_low = 8'd5;
        cfg_scl_high = 8'd4; cfg_rel = 8'd3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(step_done == 1'b0, "R1 done", step_done, 0);
        check(step_ready == 1'b1, "R1 ready", step_ready, 1);
        mon_en = 1'b1;

        bad_step(3, "write while free");
        bad_step(1, "stop while free");
        do_step(0, 0, 0, 0, 0, "start");
        do_step(3, 0, 0, 0, 0, "write0");
        do_step(3, 1, 10, 0, 0, "write1 stretched R6");
        do_step(4, 0, 0, 0, 1, "read pulled");
        do_step(4, 0, 14, 2, 0, "read glitch R12");
        bad_step(0, "start while held");
        do_step(2, 0, 0, 0, 0, "restart");
        do_step(3, 1, 0, 0, 0, "write1 R5");
        do_step(1, 0, 0, 0, 0, "stop");

        cfg_prescale = 8'd0; cfg_filt = 3'd0;
        cfg_start_su = 8'd2; cfg_start_hd = 8'd4; cfg_stop_su = 8'd1;
        cfg_dat_su = 8'd2; cfg_dat_hd = 8'd0; cfg_scl_low = 8'd3;
        cfg_scl_high = 8'd6; cfg_rel = 8'd2;
        do_step(0, 0, 0, 0, 0, "start2");
        do_step(3, 0, 0, 0, 0, "write0 fast");
        do_step(4, 0, 5, 0, 1, "read fast stretched");
        do_step(1, 0, 0, 0, 0, "stop2");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "all events seen", exp_q.size(), 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 bus released", {scl_oe, sda_oe}, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule